// File: doc/BRIEF.md
# Multi-Buffer Row Segment Cache

This block models the controller-visible behaviour of a memory device in which a bank of sixteen wide segment buffers stands between the DRAM array and the narrow data port. Column reads and writes reach only the buffers. Separate commands move a whole row segment between the array and a chosen buffer in one internal transfer, and open or close array rows in the background. Any buffer may hold any segment of any row of any bank. The intent is that each independent access stream, such as cache refill, graphics or DMA, owns a buffer, so streams that interleave do not pay the row-switch penalty.

Commands arrive on an SDRAM-style port. A two-bit operation field selects no-operation, activate, precharge or a column command. During a column command, otherwise unused address bits carry the buffer number and a two-bit extension field. That field turns the column command into a buffer read, a buffer write, a prefetch or a restore. The command port is valid/ready. The response port is valid/ready with a single response register. A command is accepted only while that register is empty or is being drained in the same cycle, so a stalled response consumer back-pressures the command source. Each accepted command other than a no-operation yields exactly one response in the next cycle. The response carries an error flag and, for a successful read, the data word. Every bank row and every buffer word starts at zero after reset.

Top module: `segbuf_cache`

## Requirements
- R1: After reset the response port is empty and every bank is closed. Every buffer is invalid and clean. Every array word reads as zero once prefetched.
- R2: cmd_ready is high exactly when rsp_valid is low or rsp_ready is high. An accepted command with cmd_op other than 0 (no-operation) raises rsp_valid in the next cycle. An accepted no-operation leaves rsp_valid low. While rsp_valid is high and rsp_ready is low, rsp_valid, rsp_err and rsp_data hold their values.
- R3: cmd_op encodes 0 as no-operation, 1 as activate, 2 as precharge and 3 as column command. For a column command, cmd_ext encodes 0 as read, 1 as write, 2 as prefetch and 3 as restore. cmd_chan names the buffer, and cmd_col names the word within the segment.
- R4: Activate on a closed bank opens cmd_row in that bank and responds without error. Activate on an open bank responds with an error and leaves the open row unchanged. Precharge always closes the bank and responds without error.
- R5: A prefetch whose bank is open on cmd_row copies all words of segment cmd_seg into buffer cmd_chan in one command, provided that buffer is not dirty. The buffer becomes valid and clean, is tagged with bank, row and segment, and no error is reported.
- R6: A prefetch to a closed bank, or to a row other than the open one, responds with an error and leaves the buffer unchanged.
- R7: A prefetch into a dirty buffer responds with an error and leaves the buffer contents, tag and dirty state unchanged.
- R8: A read of a valid buffer returns word cmd_col without error. A read of an invalid buffer returns rsp_err high with rsp_data zero. Every error response carries zero data.
- R9: A write to a valid buffer replaces word cmd_col and marks the buffer dirty, and the array is not changed. A write to an invalid buffer responds with an error and has no effect.
- R10: A restore of a valid buffer writes the whole segment back to its tagged array location whether or not that bank is open. It marks the buffer clean and keeps it valid. A restore of an invalid buffer responds with an error.
- R11: Buffers are fully associative and independent. Any buffer may hold any bank, row and segment, and the same segment may sit in several buffers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted this cycle when high with cmd_valid |
| cmd_op | input | 2 | Operation: 0 nop, 1 activate, 2 precharge, 3 column |
| cmd_ext | input | 2 | Column extension: 0 read, 1 write, 2 prefetch, 3 restore |
| cmd_bank | input | BANK_W | Bank address |
| cmd_row | input | ROW_W | Row address |
| cmd_seg | input | SEG_W | Segment index within the row |
| cmd_col | input | COL_W | Word index within the segment |
| cmd_chan | input | CH_W | Buffer select |
| cmd_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumed this cycle when high with rsp_valid |
| rsp_err | output | 1 | Command was rejected |
| rsp_data | output | DATA_W | Read data, zero for other responses |

## Verification
The bench goes after the rejection rules. A prefetch into a dirty buffer that was not blocked would silently discard written data, and a later read would return array contents instead of the written word. A prefetch on a closed bank or a mismatched row that slipped through would load the wrong segment. A restore gated on the bank being open would leave the array stale, and that would show up in the final sweep, which prefetches every segment and compares each word with the reference. The bench also stalls the response port to catch a response register that drops or changes its data, and it runs a long random interleaving of all commands across buffers that share segments, to expose tags or dirty bits that leak between buffers.

// File: rtl/segbuf_pkg.sv
package segbuf_pkg;
  typedef enum logic [1:0] {
    OP_NOP = 2'd0,
    OP_ACT = 2'd1,
    OP_PRE = 2'd2,
    OP_COL = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    EX_RD = 2'd0,
    EX_WR = 2'd1,
    EX_PF = 2'd2,
    EX_RS = 2'd3
  } ext_e;

  typedef enum logic [2:0] {
    K_NONE,
    K_ACT,
    K_PRE,
    K_RD,
    K_WR,
    K_PF,
    K_RS
  } kind_e;
endpackage

// File: rtl/segbuf_cmd_decode.sv
module segbuf_cmd_decode
  import segbuf_pkg::*;
(
  input  logic [1:0] op,
  input  logic [1:0] ext,
  output kind_e      kind
);
  always_comb begin
    kind = K_NONE;
    unique case (op_e'(op))
      OP_NOP: kind = K_NONE;
      OP_ACT: kind = K_ACT;
      OP_PRE: kind = K_PRE;
      OP_COL: begin
        unique case (ext_e'(ext))
          EX_RD: kind = K_RD;
          EX_WR: kind = K_WR;
          EX_PF: kind = K_PF;
          EX_RS: kind = K_RS;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/segbuf_bank_state.sv
module segbuf_bank_state #(
  parameter int NUM_BANK = 2,
  parameter int BANK_W   = 1,
  parameter int ROW_W    = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      act_en,
  input  logic                      pre_en,
  input  logic [BANK_W-1:0]         bank_sel,
  input  logic [ROW_W-1:0]          row_in,
  output logic [NUM_BANK-1:0]       open_vec,
  output logic [NUM_BANK*ROW_W-1:0] row_flat
);
  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    logic             open_q;
    logic [ROW_W-1:0] row_q;
    logic             hit;

    assign hit = (bank_sel == BANK_W'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        open_q <= 1'b0;
        row_q  <= '0;
      end else if (hit && pre_en) begin
        open_q <= 1'b0;
      end else if (hit && act_en) begin
        open_q <= 1'b1;
        row_q  <= row_in;
      end
    end

    assign open_vec[b]                  = open_q;
    assign row_flat[b*ROW_W +: ROW_W]   = row_q;
  end
endmodule

// File: rtl/segbuf_array_model.sv
module segbuf_array_model #(
  parameter int NUM_BANK  = 2,
  parameter int NUM_ROW   = 8,
  parameter int SEGS      = 2,
  parameter int SEG_WORDS = 8,
  parameter int DATA_W    = 16,
  parameter int BANK_W    = 1,
  parameter int ROW_W     = 3,
  parameter int SEG_W     = 1,
  localparam int SEG_BITS  = SEG_WORDS * DATA_W,
  localparam int ARR_WORDS = NUM_BANK * NUM_ROW * SEGS * SEG_WORDS,
  localparam int AW        = (ARR_WORDS > 1) ? $clog2(ARR_WORDS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [BANK_W-1:0]   wr_bank,
  input  logic [ROW_W-1:0]    wr_row,
  input  logic [SEG_W-1:0]    wr_seg,
  input  logic [SEG_BITS-1:0] wr_data,
  input  logic [BANK_W-1:0]   rd_bank,
  input  logic [ROW_W-1:0]    rd_row,
  input  logic [SEG_W-1:0]    rd_seg,
  output logic [SEG_BITS-1:0] rd_data
);
  logic [DATA_W-1:0] mem [ARR_WORDS];
  logic [AW-1:0]     rd_base;
  logic [AW-1:0]     wr_base;

  always_comb begin
    rd_base = AW'(((int'(rd_bank) * NUM_ROW + int'(rd_row)) * SEGS + int'(rd_seg)) * SEG_WORDS);
    wr_base = AW'(((int'(wr_bank) * NUM_ROW + int'(wr_row)) * SEGS + int'(wr_seg)) * SEG_WORDS);
  end

  always_comb begin
    for (int w = 0; w < SEG_WORDS; w++) begin
      rd_data[w*DATA_W +: DATA_W] = mem[rd_base + AW'(w)];
    end
  end

  // Whole segment lands in one cycle over the wide internal path.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ARR_WORDS; i++) mem[i] <= '0;
    end else if (wr_en) begin
      for (int w = 0; w < SEG_WORDS; w++) begin
        mem[wr_base + AW'(w)] <= wr_data[w*DATA_W +: DATA_W];
      end
    end
  end
endmodule

// File: rtl/segbuf_buf_file.sv
module segbuf_buf_file #(
  parameter int NUM_BUF   = 16,
  parameter int SEG_WORDS = 8,
  parameter int DATA_W    = 16,
  parameter int TAG_W     = 5,
  parameter int CH_W      = 4,
  parameter int COL_W     = 3,
  localparam int SEG_BITS = SEG_WORDS * DATA_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CH_W-1:0]     sel,
  input  logic [COL_W-1:0]    word_idx,
  input  logic                word_wr,
  input  logic [DATA_W-1:0]   word_data,
  input  logic                load_en,
  input  logic [SEG_BITS-1:0] load_data,
  input  logic [TAG_W-1:0]    load_tag,
  input  logic                clean_en,
  output logic                sel_valid,
  output logic                sel_dirty,
  output logic [TAG_W-1:0]    sel_tag,
  output logic [DATA_W-1:0]   sel_word,
  output logic [SEG_BITS-1:0] sel_seg,
  output logic [NUM_BUF-1:0]  dirty_vec
);
  logic [SEG_BITS-1:0] seg_q [NUM_BUF];
  logic [TAG_W-1:0]    tag_q [NUM_BUF];
  logic [NUM_BUF-1:0]  valid_q;
  logic [NUM_BUF-1:0]  dirty_q;

  for (genvar i = 0; i < NUM_BUF; i++) begin : g_buf
    logic hit;
    assign hit = (sel == CH_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[i] <= 1'b0;
        dirty_q[i] <= 1'b0;
        tag_q[i]   <= '0;
        seg_q[i]   <= '0;
      end else if (hit) begin
        if (load_en) begin
          seg_q[i]   <= load_data;
          tag_q[i]   <= load_tag;
          valid_q[i] <= 1'b1;
          dirty_q[i] <= 1'b0;
        end else if (word_wr) begin
          seg_q[i][int'(word_idx)*DATA_W +: DATA_W] <= word_data;
          dirty_q[i] <= 1'b1;
        end else if (clean_en) begin
          dirty_q[i] <= 1'b0;
        end
      end
    end
  end

  assign sel_valid = valid_q[sel];
  assign sel_dirty = dirty_q[sel];
  assign sel_tag   = tag_q[sel];
  assign sel_seg   = seg_q[sel];
  assign sel_word  = sel_seg[int'(word_idx)*DATA_W +: DATA_W];
  assign dirty_vec = dirty_q;
endmodule

// File: rtl/segbuf_cache.sv
module segbuf_cache
  import segbuf_pkg::*;
#(
  parameter int NUM_BUF      = 16,
  parameter int NUM_BANK     = 2,
  parameter int NUM_ROW      = 8,
  parameter int SEGS_PER_ROW = 2,
  parameter int SEG_WORDS    = 8,
  parameter int DATA_W       = 16,
  parameter int CH_W   = (NUM_BUF > 1)      ? $clog2(NUM_BUF)      : 1,
  parameter int BANK_W = (NUM_BANK > 1)     ? $clog2(NUM_BANK)     : 1,
  parameter int ROW_W  = (NUM_ROW > 1)      ? $clog2(NUM_ROW)      : 1,
  parameter int SEG_W  = (SEGS_PER_ROW > 1) ? $clog2(SEGS_PER_ROW) : 1,
  parameter int COL_W  = (SEG_WORDS > 1)    ? $clog2(SEG_WORDS)    : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [1:0]        cmd_ext,
  input  logic [BANK_W-1:0] cmd_bank,
  input  logic [ROW_W-1:0]  cmd_row,
  input  logic [SEG_W-1:0]  cmd_seg,
  input  logic [COL_W-1:0]  cmd_col,
  input  logic [CH_W-1:0]   cmd_chan,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_data
);
  localparam int TAG_W    = BANK_W + ROW_W + SEG_W;
  localparam int SEG_BITS = SEG_WORDS * DATA_W;

  kind_e                      kind;
  logic                       fire;
  logic [NUM_BANK-1:0]        open_vec;
  logic [NUM_BANK*ROW_W-1:0]  row_flat;
  logic                       bank_open;
  logic [ROW_W-1:0]           open_row;
  logic                       sel_valid;
  logic                       sel_dirty;
  logic [TAG_W-1:0]           sel_tag;
  logic [DATA_W-1:0]          sel_word;
  logic [SEG_BITS-1:0]        sel_seg;
  logic [NUM_BUF-1:0]         buf_dirty;
  logic [SEG_BITS-1:0]        arr_seg;
  logic                       err;
  logic                       act_en;
  logic                       pre_en;
  logic                       word_wr;
  logic                       load_en;
  logic                       clean_en;
  logic [BANK_W-1:0]          tag_bank;
  logic [ROW_W-1:0]           tag_row;
  logic [SEG_W-1:0]           tag_seg;

  segbuf_cmd_decode u_dec (
    .op   (cmd_op),
    .ext  (cmd_ext),
    .kind (kind)
  );

  assign cmd_ready = !rsp_valid || rsp_ready;
  assign fire      = cmd_valid && cmd_ready;
  assign bank_open = open_vec[cmd_bank];
  assign open_row  = row_flat[int'(cmd_bank)*ROW_W +: ROW_W];
  assign {tag_bank, tag_row, tag_seg} = sel_tag;

  always_comb begin
    err = 1'b0;
    unique case (kind)
      K_ACT:              err = bank_open;
      K_RD, K_WR, K_RS:   err = !sel_valid;
      K_PF:               err = !bank_open || (open_row != cmd_row) || sel_dirty;
      default:            err = 1'b0;
    endcase
  end

  assign act_en   = fire && (kind == K_ACT) && !err;
  assign pre_en   = fire && (kind == K_PRE);
  assign word_wr  = fire && (kind == K_WR) && !err;
  assign load_en  = fire && (kind == K_PF) && !err;
  assign clean_en = fire && (kind == K_RS) && !err;

  segbuf_bank_state #(
    .NUM_BANK (NUM_BANK),
    .BANK_W   (BANK_W),
    .ROW_W    (ROW_W)
  ) u_banks (
    .clk      (clk),
    .rst_n    (rst_n),
    .act_en   (act_en),
    .pre_en   (pre_en),
    .bank_sel (cmd_bank),
    .row_in   (cmd_row),
    .open_vec (open_vec),
    .row_flat (row_flat)
  );

  segbuf_array_model #(
    .NUM_BANK  (NUM_BANK),
    .NUM_ROW   (NUM_ROW),
    .SEGS      (SEGS_PER_ROW),
    .SEG_WORDS (SEG_WORDS),
    .DATA_W    (DATA_W),
    .BANK_W    (BANK_W),
    .ROW_W     (ROW_W),
    .SEG_W     (SEG_W)
  ) u_array (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (clean_en),
    .wr_bank (tag_bank),
    .wr_row  (tag_row),
    .wr_seg  (tag_seg),
    .wr_data (sel_seg),
    .rd_bank (cmd_bank),
    .rd_row  (cmd_row),
    .rd_seg  (cmd_seg),
    .rd_data (arr_seg)
  );

  segbuf_buf_file #(
    .NUM_BUF   (NUM_BUF),
    .SEG_WORDS (SEG_WORDS),
    .DATA_W    (DATA_W),
    .TAG_W     (TAG_W),
    .CH_W      (CH_W),
    .COL_W     (COL_W)
  ) u_bufs (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (cmd_chan),
    .word_idx  (cmd_col),
    .word_wr   (word_wr),
    .word_data (cmd_wdata),
    .load_en   (load_en),
    .load_data (arr_seg),
    .load_tag  ({cmd_bank, cmd_row, cmd_seg}),
    .clean_en  (clean_en),
    .sel_valid (sel_valid),
    .sel_dirty (sel_dirty),
    .sel_tag   (sel_tag),
    .sel_word  (sel_word),
    .sel_seg   (sel_seg),
    .dirty_vec (buf_dirty)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_data  <= '0;
    end else if (fire && (kind != K_NONE)) begin
      rsp_valid <= 1'b1;
      rsp_err   <= err;
      rsp_data  <= ((kind == K_RD) && !err) ? sel_word : '0;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/segbuf_cache_chk.sv
module segbuf_cache_chk #(
  parameter int NUM_BUF = 16,
  parameter int CH_W    = 4,
  parameter int DATA_W  = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmd_valid,
  input logic               cmd_ready,
  input logic [1:0]         cmd_op,
  input logic [1:0]         cmd_ext,
  input logic [CH_W-1:0]    cmd_chan,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic               rsp_err,
  input logic [DATA_W-1:0]  rsp_data,
  input logic [NUM_BUF-1:0] dirty_vec
);
  logic acc;
  assign acc = cmd_valid && cmd_ready;

  // R1
  reset_empty_chk: assert property (@(posedge clk) !rst_n |=> !rsp_valid);

  // R2
  rsp_follows_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op != 2'd0) |=> rsp_valid);

  // R2
  nop_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 2'd0) |=> !rsp_valid);

  // R2
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_err)));

  // R8
  err_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_data == '0));

  // R7
  dirty_pf_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 2'd3 && cmd_ext == 2'd2 && dirty_vec[cmd_chan]) |=> (rsp_valid && rsp_err));

  // R9
  write_dirty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 2'd3 && cmd_ext == 2'd1) |=> (dirty_vec[$past(cmd_chan)] == !rsp_err));

  // R10
  restore_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && cmd_op == 2'd3 && cmd_ext == 2'd3) |=> !dirty_vec[$past(cmd_chan)]);
endmodule

bind segbuf_cache segbuf_cache_chk #(
  .NUM_BUF (NUM_BUF),
  .CH_W    (CH_W),
  .DATA_W  (DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_op    (cmd_op),
  .cmd_ext   (cmd_ext),
  .cmd_chan  (cmd_chan),
  .rsp_valid (rsp_valid),
  .rsp_ready (rsp_ready),
  .rsp_err   (rsp_err),
  .rsp_data  (rsp_data),
  .dirty_vec (buf_dirty)
);

// File: tb/segbuf_cache_tb.sv
module segbuf_cache_tb;
  localparam int NB = 16;
  localparam int NK = 2;
  localparam int NR = 8;
  localparam int NS = 2;
  localparam int NW = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = '0;
  logic [1:0]  cmd_ext = '0;
  logic [0:0]  cmd_bank = '0;
  logic [2:0]  cmd_row = '0;
  logic [0:0]  cmd_seg = '0;
  logic [2:0]  cmd_col = '0;
  logic [3:0]  cmd_chan = '0;
  logic [15:0] cmd_wdata = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b1;
  logic        rsp_err;
  logic [15:0] rsp_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // behavioural reference state
  logic [15:0] r_arr [NK*NR*NS*NW];
  logic [15:0] r_buf [NB][NW];
  bit          r_val [NB];
  bit          r_dirty [NB];
  int          r_tag [NB];
  bit          r_open [NK];
  int          r_orow [NK];

  always #2 clk = ~clk;

  segbuf_cache u_dut (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_ext(cmd_ext), .cmd_bank(cmd_bank),
    .cmd_row(cmd_row), .cmd_seg(cmd_seg), .cmd_col(cmd_col),
    .cmd_chan(cmd_chan), .cmd_wdata(cmd_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_err(rsp_err), .rsp_data(rsp_data)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // ready is checked every cycle against the handshake rule (R2)
  always @(negedge clk) begin
    if (rst_n) chk(cmd_ready == (!rsp_valid || rsp_ready), "R2", "cmd_ready",
                   int'(cmd_ready), int'(!rsp_valid || rsp_ready));
  end

  task automatic issue(input int op, input int ext, input int bank, input int row,
                       input int seg, input int col, input int chan,
                       input logic [15:0] wd, input string req);
    bit          e_err;
    logic [15:0] e_dat;
    int          base;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = 2'(op); cmd_ext = 2'(ext);
    cmd_bank = 1'(bank); cmd_row = 3'(row); cmd_seg = 1'(seg);
    cmd_col = 3'(col); cmd_chan = 4'(chan); cmd_wdata = wd;
    @(posedge clk);
    #1 cmd_valid = 1'b0; cmd_op = '0;
    e_err = 1'b0; e_dat = '0;
    if (op == 1) begin
      if (r_open[bank]) e_err = 1'b1;
      else begin r_open[bank] = 1'b1; r_orow[bank] = row; end
    end else if (op == 2) begin
      r_open[bank] = 1'b0;
    end else if (op == 3) begin
      case (ext)
        0: if (!r_val[chan]) e_err = 1'b1; else e_dat = r_buf[chan][col];
        1: if (!r_val[chan]) e_err = 1'b1;
           else begin r_buf[chan][col] = wd; r_dirty[chan] = 1'b1; end
        2: if (!r_open[bank] || r_orow[bank] != row || r_dirty[chan]) e_err = 1'b1;
           else begin
             base = ((bank * NR + row) * NS + seg) * NW;
             for (int w = 0; w < NW; w++) r_buf[chan][w] = r_arr[base + w];
             r_val[chan] = 1'b1; r_tag[chan] = base;
           end
        default: if (!r_val[chan]) e_err = 1'b1;
           else begin
             for (int w = 0; w < NW; w++) r_arr[r_tag[chan] + w] = r_buf[chan][w];
             r_dirty[chan] = 1'b0;
           end
      endcase
    end
    @(negedge clk);
    if (op == 0) begin
      chk(rsp_valid == 1'b0, req, "nop rsp_valid", int'(rsp_valid), 0);
    end else begin
      chk(rsp_valid == 1'b1, req, "rsp_valid", int'(rsp_valid), 1);
      chk(rsp_err == e_err, req, "rsp_err", int'(rsp_err), int'(e_err));
      chk(rsp_data == e_dat, req, "rsp_data", int'(rsp_data), int'(e_dat));
    end
  endtask

  initial begin
    for (int i = 0; i < NK*NR*NS*NW; i++) r_arr[i] = '0;
    for (int c = 0; c < NB; c++) begin
      r_val[c] = 0; r_dirty[c] = 0; r_tag[c] = 0;
      for (int w = 0; w < NW; w++) r_buf[c][w] = '0;
    end
    for (int b = 0; b < NK; b++) begin r_open[b] = 0; r_orow[b] = 0; end

    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R1", "reset rsp_valid", int'(rsp_valid), 0);
    rst_n = 1'b1;

    // R1: everything invalid and closed
    issue(3, 0, 0, 0, 0, 0, 0, 16'h0, "R1");
    issue(3, 2, 0, 0, 0, 0, 1, 16'h0, "R1");
    // R2: no-operation gives no response
    issue(0, 0, 0, 0, 0, 0, 0, 16'h0, "R2");
    // R4: activate then double activate
    issue(1, 0, 0, 2, 0, 0, 0, 16'h0, "R4");
    issue(1, 0, 0, 3, 0, 0, 0, 16'h0, "R4");
    // R6: wrong row, R5: correct row
    issue(3, 2, 0, 3, 1, 0, 5, 16'h0, "R6");
    issue(3, 0, 0, 0, 0, 3, 5, 16'h0, "R6");
    issue(3, 2, 0, 2, 1, 0, 5, 16'h0, "R5");
    issue(3, 0, 0, 0, 0, 3, 5, 16'h0, "R5");
    // R9: write valid, write invalid
    issue(3, 1, 0, 0, 0, 3, 5, 16'hBEEF, "R9");
    issue(3, 0, 0, 0, 0, 3, 5, 16'h0, "R9");
    issue(3, 1, 0, 0, 0, 3, 6, 16'h1234, "R9");
    issue(3, 0, 0, 0, 0, 3, 6, 16'h0, "R9");
    // R11: same segment in a second buffer still sees the array value
    issue(3, 2, 0, 2, 1, 0, 7, 16'h0, "R11");
    issue(3, 0, 0, 0, 0, 3, 7, 16'h0, "R11");
    // R7: dirty buffer rejects prefetch and keeps its data
    issue(3, 2, 0, 2, 0, 0, 5, 16'h0, "R7");
    issue(3, 0, 0, 0, 0, 3, 5, 16'h0, "R7");
    // R4: precharge; R10: restore with bank closed
    issue(2, 0, 0, 0, 0, 0, 0, 16'h0, "R4");
    issue(3, 3, 0, 0, 0, 0, 5, 16'h0, "R10");
    issue(3, 3, 0, 0, 0, 0, 6, 16'h0, "R10");
    issue(3, 2, 0, 2, 1, 0, 9, 16'h0, "R6");
    issue(1, 0, 0, 2, 0, 0, 0, 16'h0, "R4");
    issue(3, 2, 0, 2, 1, 0, 9, 16'h0, "R10");
    issue(3, 0, 0, 0, 0, 3, 9, 16'h0, "R10");
    issue(3, 2, 0, 2, 0, 0, 5, 16'h0, "R7");
    // R11: other bank into highest buffer
    issue(1, 0, 1, 7, 0, 0, 0, 16'h0, "R11");
    issue(3, 2, 1, 7, 0, 0, 15, 16'h0, "R11");
    issue(3, 1, 0, 0, 0, 7, 15, 16'hA5A5, "R11");
    issue(3, 0, 0, 0, 0, 7, 15, 16'h0, "R11");

    // R2: stalled response holds and blocks commands
    rsp_ready = 1'b0;
    issue(3, 0, 0, 0, 0, 7, 15, 16'h0, "R2");
    @(negedge clk);
    chk(cmd_ready == 1'b0, "R2", "stall cmd_ready", int'(cmd_ready), 0);
    chk(rsp_valid == 1'b1, "R2", "stall rsp_valid", int'(rsp_valid), 1);
    chk(rsp_data == 16'hA5A5, "R2", "stall rsp_data", int'(rsp_data), 16'hA5A5);
    rsp_ready = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R2", "drain rsp_valid", int'(rsp_valid), 0);

    // R3/R11: random interleaving of every command
    for (int n = 0; n < 600; n++) begin
      int k;
      k = int'($urandom_range(0, 9));
      if (k == 0)      issue(1, 0, int'($urandom_range(0, 1)), int'($urandom_range(0, 3)), 0, 0, 0, 16'h0, "R3");
      else if (k == 1) issue(2, 0, int'($urandom_range(0, 1)), 0, 0, 0, 0, 16'h0, "R3");
      else begin
        issue(3, (k < 4) ? 0 : (k < 6) ? 1 : (k < 8) ? 2 : 3,
              int'($urandom_range(0, 1)), int'($urandom_range(0, 3)),
              int'($urandom_range(0, 1)), int'($urandom_range(0, 7)),
              int'($urandom_range(0, 15)), 16'($urandom), "R11");
      end
    end

    // R10: flush every buffer, then sweep the whole array
    for (int c = 0; c < NB; c++) issue(3, 3, 0, 0, 0, 0, c, 16'h0, "R10");
    for (int b = 0; b < NK; b++) begin
      issue(2, 0, b, 0, 0, 0, 0, 16'h0, "R4");
      for (int r = 0; r < NR; r++) begin
        issue(1, 0, b, r, 0, 0, 0, 16'h0, "R4");
        for (int s = 0; s < NS; s++) begin
          issue(3, 2, b, r, s, 0, 0, 16'h0, "R10");
          for (int w = 0; w < NW; w++) issue(3, 0, 0, 0, 0, w, 0, 16'h0, "R10");
        end
        issue(2, 0, b, 0, 0, 0, 0, 16'h0, "R4");
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule